// File: doc/BRIEF.md
# I2S to Right-Justified Serial Audio Converter

This block re-frames a two-channel, 16-bit serial audio stream. The input uses I2S framing: each channel has a slot of 32 bit-clock periods, and the word-select line changes one bit period before the sample's MSB. The output uses right-justified framing, in which the sample's LSB falls on the final bit of its slot. The whole block runs on the serial bit clock. The bit clock itself is not routed through the block. It goes to the downstream converter unchanged.

The data line passes through a fixed delay of fifteen bit periods. That figure is the sixteen-bit shift from the head of the slot to its tail, minus the one-bit lead that I2S gives the MSB. Word-select is inverted combinationally and is not delayed. Each sample therefore keeps the exact bit-clock phase it arrived with. It is never captured into a word register and shifted out again. A mode input can force the sixteen leading bits of each output slot, which the receiver ignores, to zero.

Top module: `i2srj_converter`

## Requirements
- R1: `ws_out` is the logical inverse of `ws_in` at all times, with no clock delay.
- R2: The data value sampled from `sd_in` on rising edge n appears on `sd_out` after rising edge n+14, so a receiver reading on rising edges sees it 15 bit periods later.
- R3: Slot position 0 is the rising edge at which a new level of `ws_in` is first sampled. The receiver reads the 16-bit sample MSB first at positions 16 to 31 of each output slot. The left channel is the slot sent with `ws_in` low, and it is read while `ws_out` is high.
- R4: With `fill_zero` = 1, `sd_out` reads as 0 at positions 0 to 15 of every output slot. `fill_zero` is changed only while in reset.
- R5: With `fill_zero` = 0, positions 0 to 15 carry the delayed input bits unaltered, as R2 describes.
- R6: A rising edge with `rst_n` low clears the delay line and the slot tracking. `sd_out` then reads 0 until the receiver position that follows the first `ws_in` change sampled after reset. The first `ws_in` value sampled after reset is not treated as a change.
- R7: The slot bit counter restarts at every sampled `ws_in` change, so zero-fill follows the word-select edges rather than a free-running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock. All state changes on its rising edge. |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_zero | input | 1 | 1 forces the leading 16 bits of each output slot to zero |
| ws_in | input | 1 | I2S word select (0 = left channel) |
| sd_in | input | 1 | I2S serial data, sampled on the rising edge |
| ws_out | output | 1 | Right-justified word select, the inverse of `ws_in` |
| sd_out | output | 1 | Right-justified serial data, delayed 15 bit periods |

## Verification
Word-select is checked one time step after each input change, because it has no clock stage. The data bit sampled at edge n is due on `sd_out` after edge n+14. The bench therefore reads `sd_out` on the falling edge just before it drives tick n+15, which is the same moment a receiver would latch it. The reference keeps a history of every driven bit and indexes it fifteen ticks back. It also keeps its own slot position, so zero-fill, the post-reset hold and the reassembly of whole 16-bit words are all scored at the tick the receiver would read them.

// File: rtl/i2srj_pkg.sv
// Package: shared framing constants for the I2S to right-justified converter.
// Assumes a fixed slot size and sample width. Everything else is derived.
package i2srj_pkg;
    localparam int SLOT_BITS   = 32;
    localparam int SAMPLE_BITS = 16;
    // Justification shift minus the one-bit I2S lead.
    localparam int DELAY_BITS  = SLOT_BITS - SAMPLE_BITS - 1;
    localparam int CNT_W       = $clog2(SLOT_BITS);
endpackage

// File: rtl/i2srj_delay_line.sv
// Module: fixed-length serial delay line on the bit clock.
// What it does: the bit sampled at edge n leaves the last stage after edge n+DEPTH-1.
// Assumes: synchronous active-low reset clears every stage.
module i2srj_delay_line #(
    parameter int DEPTH = 15
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage_q;

    // Purpose: first stage samples the serial input.
    always_ff @(posedge bclk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= din;
    end

    // Purpose: every later stage copies its predecessor.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge bclk) begin
            if (!rst_n) stage_q[g] <= 1'b0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/i2srj_slot_tracker.sv
// Module: follows word-select edges and decides when delayed data may reach the output.
// What it does: counts bit periods from each sampled ws change, flags the first change
// after reset, and raises pass_o while the output may carry data.
// Assumes: fill_zero is held steady except during reset.
module i2srj_slot_tracker #(
    parameter int SLOT_BITS   = 32,
    parameter int SAMPLE_BITS = 16,
    parameter int CNT_W       = 5
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic ws_in,
    input  logic fill_zero,
    output logic pass_o
);
    // Counter values after which the output carries slot positions 16..31.
    localparam int WIN_LO = SLOT_BITS - SAMPLE_BITS - 1;
    localparam int WIN_HI = SLOT_BITS - 2;

    logic             ws_q, ws_vld_q, seen_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ws_edge, in_window;

    assign ws_edge   = ws_vld_q && (ws_in != ws_q);
    assign in_window = (cnt_q >= CNT_W'(WIN_LO)) && (cnt_q <= CNT_W'(WIN_HI));

    // Purpose: remember the last ws level and whether it is valid since reset.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            ws_q     <= 1'b0;
            ws_vld_q <= 1'b0;
        end else begin
            ws_q     <= ws_in;
            ws_vld_q <= 1'b1;
        end
    end

    // Purpose: restart the bit counter on each ws change and note the first change.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (ws_edge) begin
            cnt_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Purpose: data may pass once aligned, and only inside the window when zero-filling.
    always_comb begin
        pass_o = seen_q && (!fill_zero || in_window);
    end

    // R4: in zero-fill mode the pass window is exactly SAMPLE_BITS periods wide.
    a_r4_window_len: assert property (@(posedge bclk) disable iff (!rst_n)
        ($fell(pass_o) && fill_zero) |-> ($past(pass_o, 16) && !$past(pass_o, 17)));

    // R7: the counter restarts on a ws change and must not hold an open window right after it.
    a_r7_restart_closed: assert property (@(posedge bclk) disable iff (!rst_n)
        (ws_edge && fill_zero) |=> !pass_o);
endmodule

// File: rtl/i2srj_out_gate.sv
// Module: output gating for the serial data line.
// What it does: forwards the delayed bit when allowed, otherwise drives zero.
// Assumes: pass is already registered-state based, so there is no glitch source beyond one AND.
module i2srj_out_gate (
    input  logic tail_bit,
    input  logic pass,
    output logic sd_out
);
    // Purpose: hold zero whenever the tracker does not allow data through.
    always_comb begin
        sd_out = tail_bit & pass;
    end
endmodule

// File: rtl/i2srj_converter.sv
// Module: I2S to right-justified converter, top level.
// What it does: delays serial data by DELAY_BITS bit periods, inverts word select,
// and optionally zeroes the leading don't-care bits of each output slot.
// Assumes: 32-bit slots, 16-bit samples, and a bit clock that reaches the receiver directly.
module i2srj_converter
    import i2srj_pkg::*;
(
    input  logic bclk,
    input  logic rst_n,
    input  logic fill_zero,
    input  logic ws_in,
    input  logic sd_in,
    output logic ws_out,
    output logic sd_out
);
    localparam int AGE_W = $clog2(DELAY_BITS + 1);

    logic tail_bit, pass;

    // Purpose: word select for the receiver is the inverted input, with no delay.
    assign ws_out = ~ws_in;

    i2srj_delay_line #(.DEPTH(DELAY_BITS)) u_delay (
        .bclk (bclk),
        .rst_n(rst_n),
        .din  (sd_in),
        .dout (tail_bit)
    );

    i2srj_slot_tracker #(
        .SLOT_BITS  (SLOT_BITS),
        .SAMPLE_BITS(SAMPLE_BITS),
        .CNT_W      (CNT_W)
    ) u_track (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .ws_in    (ws_in),
        .fill_zero(fill_zero),
        .pass_o   (pass)
    );

    i2srj_out_gate u_gate (
        .tail_bit(tail_bit),
        .pass    (pass),
        .sd_out  (sd_out)
    );

    // Purpose: count edges since reset, saturating at the delay depth (for checks only).
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge bclk) begin
        if (!rst_n)                         age_q <= '0;
        else if (age_q != AGE_W'(DELAY_BITS)) age_q <= age_q + 1'b1;
    end

    // R2: when data passes, the output equals the input from DELAY_BITS edges earlier.
    a_r2_delay: assert property (@(posedge bclk) disable iff (!rst_n)
        (age_q == AGE_W'(DELAY_BITS) && pass) |-> (sd_out == $past(sd_in, DELAY_BITS)));

    // R6: before tracking allows data, the output stays low even while the delay line fills.
    a_r6_hold_zero: assert property (@(posedge bclk) disable iff (!rst_n)
        (age_q == '0) |-> (sd_out == 1'b0));

    // R1: the word-select output always disagrees with its input.
    always_comb begin
        a_r1_ws_inverse: assert (ws_out !== ws_in || $isunknown(ws_in));
    end
endmodule

// File: tb/i2srj_converter_tb_top.sv
`timescale 1ns/1ps
module i2srj_converter_tb_top;
    logic bclk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_zero = 1'b0;
    logic ws_in = 1'b1;
    logic sd_in = 1'b0;
    logic ws_out, sd_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 bclk = ~bclk;

    i2srj_converter dut_i (
        .bclk(bclk), .rst_n(rst_n), .fill_zero(fill_zero),
        .ws_in(ws_in), .sd_in(sd_in), .ws_out(ws_out), .sd_out(sd_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reset, idle, then stream nslots of I2S frames and score every receiver bit.
    task automatic run_stream(input int nslots, input bit fz);
        bit          hist[$];
        logic [15:0] sent[$];
        logic [15:0] word = '0;
        logic [15:0] smp = '0;
        rst_n = 1'b0; fill_zero = fz; ws_in = 1'b1; sd_in = 1'b1;
        repeat (3) @(negedge bclk);
        check("R6 in reset", sd_out, 0);
        rst_n = 1'b1; sd_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge bclk);
            check("R6 idle after reset", sd_out, 0);
        end
        for (int t = 0; t < nslots * 32; t++) begin
            int  s = t / 32;
            int  pos = t % 32;
            bit  eb;
            string tag;
            @(negedge bclk);
            // Receiver reads sd_out at edge t: value set by edge t-1.
            eb = (t == 0 || t < 15) ? 1'b0 : hist[t-15];
            if (pos < 16 && fz) eb = 1'b0;
            if (t == 0)        tag = "R6 hold before first ws change";
            else if (pos >= 16) tag = "R2 delayed data";
            else if (fz)       tag = "R4 zero fill / R7 realign";
            else               tag = "R5 leading bits passed";
            check(tag, sd_out, eb);
            if (pos >= 16) begin
                word = {word[14:0], sd_out};
                if (pos == 31) begin
                    check("R3 word reassembly", word, sent[s]);
                    check("R3 left while ws_out high", ws_out, (s % 2 == 0) ? 1 : 0);
                end
            end
            // Drive tick t.
            if (pos == 0) begin
                ws_in = s[0];
                smp = 16'($urandom);
                sent.push_back(smp);
            end
            if (pos >= 1 && pos <= 16) sd_in = smp[16-pos];
            else                       sd_in = 1'($urandom);
            hist.push_back(sd_in);
            #1;
            check("R1 ws inverse", ws_out, !ws_in);
        end
    endtask

    initial begin
        run_stream(8, 1'b0);
        run_stream(8, 1'b1);
        run_stream(4, 1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule